// File: doc/BRIEF.md
# Signed Long Divide Unit

This block divides a signed 32-bit dividend by a signed 16-bit divisor. It returns a 16-bit quotient, a 16-bit remainder and four condition flags: negative (N), zero (Z), overflow (V) and carry (C). The dividend arrives as two words that a register file reads from an even/odd register pair. The high word comes from the even register and the low word from the odd one. The 3-bit register index travels with the operands, so the unit can refuse an odd index.

A one-cycle `start` pulse launches an operation. Some cases need no division: an odd register index, a zero divisor, and the most negative dividend divided by minus one. Each of these ends on the clock edge that samples `start`. Every other operation runs a magnitude divider, one quotient bit per cycle over 32 iterations. A sign fix-up then truncates the quotient toward zero and gives the remainder the sign of the dividend. On success the unit pulses write enables for both registers of the pair. On every failure it leaves the registers alone and reports the failure through the flags only.

Top module: `long_div_unit`

## Requirements
- R1: An odd `reg_idx` (bit 0 set) gives `trap`=1 and `done`=1 in the cycle right after the sampling edge. No write enable rises, and `quotient`, `remainder` and the flags keep their previous values.
- R2: The dividend is `{dvd_hi, dvd_lo}` as a two's-complement 32-bit value, where `dvd_hi` is the even-register word.
- R3: A zero divisor gives N=0, Z=1, V=1, C=1 with `done` in the cycle after the sampling edge, and no register write.
- R4: A dividend of 0x80000000 with a divisor of 0xFFFF gives N=0, Z=0, V=1, C=0 with `done` in the cycle after the sampling edge, and no register write.
- R5: The quotient is truncated toward zero and is negative when the operand signs differ. A nonzero remainder takes the sign of the dividend.
- R6: A true quotient outside -32768..32767 gives V=1, Z=0, C=0 and N=1 exactly when the quotient is negative. No write enable rises and `quotient`/`remainder` hold their previous values.
- R7: On success `wr_even` and `wr_odd` pulse together with `done`. `quotient` carries the even-register value and `remainder` the odd-register value. N is bit 15 of the quotient, Z=1 when the quotient is zero, and V=C=0.
- R8: An operation that divides raises `done` for one cycle, 2*DW+1 clock edges after the edge that sampled `start` (33 for DW=16).
- R9: After reset, all outputs are zero.
- R10: A `start` pulse that arrives while a division is running is ignored, and the running result is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch strobe |
| reg_idx | input | RIW (3) | Destination register index |
| dvd_hi | input | DW (16) | Dividend high word (even register) |
| dvd_lo | input | DW (16) | Dividend low word (odd register) |
| divisor | input | DW (16) | Signed divisor |
| quotient | output | DW (16) | Value for the even register |
| remainder | output | DW (16) | Value for the odd register |
| wr_even | output | 1 | Write enable, even register |
| wr_odd | output | 1 | Write enable, odd register |
| trap | output | 1 | Reserved-instruction trap pulse |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (divide by zero) |
| done | output | 1 | Completion pulse |

## Verification
The assertions check the following on every cycle:
- A trap never comes with a register write.
- A set overflow flag always suppresses both write enables, and both write enables always rise together.
- A set carry flag always comes with V and Z set.
- `quotient` and `remainder` hold on any completion without a write.
- Inside the divider, the partial remainder stays below the divisor magnitude.

Only the scenarios can show that the quotient and remainder values are correct, with the right truncation and signs. The same holds for the exact overflow boundaries at +32767 and -32768, the completion latency of each path, and that a `start` pulse during a running division is ignored.

// File: rtl/ldiv_pkg.sv
package ldiv_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccode_t;

  typedef enum logic [1:0] {
    CLS_DIVIDE = 2'd0,
    CLS_TRAP   = 2'd1,
    CLS_ZERO   = 2'd2,
    CLS_MAXNEG = 2'd3
  } cls_e;

endpackage

// File: rtl/ldiv_classify.sv
module ldiv_classify
  import ldiv_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RIW = 3
) (
  input  logic [RIW-1:0]  reg_idx,
  input  logic [2*DW-1:0] dvd,
  input  logic [DW-1:0]   dvs,
  output cls_e            cls,
  output logic [2*DW-1:0] dvd_mag,
  output logic [DW-1:0]   dvs_mag,
  output logic            dvd_neg,
  output logic            dvs_neg
);
  localparam int QW = 2 * DW;
  localparam logic [QW-1:0] MOST_NEG = {1'b1, {(QW-1){1'b0}}};

  logic odd_idx;

  assign odd_idx = (reg_idx & RIW'(1)) != '0;
  assign dvd_neg = dvd[QW-1];
  assign dvs_neg = dvs[DW-1];
  assign dvd_mag = dvd_neg ? (~dvd + QW'(1)) : dvd;
  assign dvs_mag = dvs_neg ? (~dvs + DW'(1)) : dvs;

  always_comb begin
    if (odd_idx)                            cls = CLS_TRAP;
    else if (dvs == '0)                     cls = CLS_ZERO;
    else if (dvd == MOST_NEG && dvs == '1)  cls = CLS_MAXNEG;
    else                                    cls = CLS_DIVIDE;
  end
endmodule

// File: rtl/ldiv_mag_core.sv
module ldiv_mag_core #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [2*DW-1:0] dvd_mag,
  input  logic [DW-1:0]   dvs_mag,
  output logic            busy,
  output logic            fin,
  output logic [2*DW-1:0] q_mag,
  output logic [DW-1:0]   r_mag
);
  localparam int QW = 2 * DW;
  localparam int CW = $clog2(QW);

  logic [QW-1:0] acc_q;
  logic [DW-1:0] acc_r;
  logic [DW-1:0] den;
  logic [CW-1:0] cnt;
  logic [DW:0]   shifted;
  logic [DW-1:0] diff;
  logic          take;
  logic [DW-1:0] next_r;

  assign shifted = {acc_r, acc_q[QW-1]};
  assign take    = shifted >= {1'b0, den};
  assign diff    = shifted[DW-1:0] - den;
  assign next_r  = take ? diff : shifted[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      acc_r <= '0;
      den   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load && !busy) begin
        acc_q <= dvd_mag;
        acc_r <= '0;
        den   <= dvs_mag;
        cnt   <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        acc_q <= {acc_q[QW-2:0], take};
        acc_r <= next_r;
        cnt   <= cnt + CW'(1);
        if (cnt == CW'(QW - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign q_mag = acc_q;
  assign r_mag = acc_r;

  // R5: partial remainder never reaches the divisor magnitude
  assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (acc_r < den));

  // R8: completion strobe only at the end of an iteration run
  assert_fin_after_run_R8: assert property (@(posedge clk) disable iff (rst)
    fin |-> (!busy && $past(busy)));
endmodule

// File: rtl/ldiv_fixup.sv
module ldiv_fixup
  import ldiv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2*DW-1:0] q_mag,
  input  logic [DW-1:0]   r_mag,
  input  logic            dvd_neg,
  input  logic            dvs_neg,
  output logic [DW-1:0]   q_word,
  output logic [DW-1:0]   r_word,
  output logic            ok,
  output ccode_t          cc
);
  localparam int QW = 2 * DW;
  localparam logic [QW-1:0] POS_MAX = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [QW-1:0] NEG_MAX = POS_MAX + QW'(1);

  logic          q_neg;
  logic          ovf;
  logic [QW-1:0] q_full;

  assign q_neg  = dvd_neg ^ dvs_neg;
  assign ovf    = q_neg ? (q_mag > NEG_MAX) : (q_mag > POS_MAX);
  assign q_full = q_neg ? (~q_mag + QW'(1)) : q_mag;
  assign q_word = q_full[DW-1:0];
  assign r_word = dvd_neg ? (~r_mag + DW'(1)) : r_mag;
  assign ok     = !ovf;

  always_comb begin
    if (ovf) begin
      cc = '{n: q_neg, z: 1'b0, v: 1'b1, c: 1'b0};
    end else begin
      cc = '{n: q_word[DW-1], z: (q_word == '0), v: 1'b0, c: 1'b0};
    end
  end
endmodule

// File: rtl/long_div_unit.sv
module long_div_unit
  import ldiv_pkg::*;
#(
  parameter int DW  = 16,
  parameter int RIW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [RIW-1:0] reg_idx,
  input  logic [DW-1:0]  dvd_hi,
  input  logic [DW-1:0]  dvd_lo,
  input  logic [DW-1:0]  divisor,
  output logic [DW-1:0]  quotient,
  output logic [DW-1:0]  remainder,
  output logic           wr_even,
  output logic           wr_odd,
  output logic           trap,
  output logic           flag_n,
  output logic           flag_z,
  output logic           flag_v,
  output logic           flag_c,
  output logic           done
);
  localparam int QW = 2 * DW;

  cls_e          cls;
  logic [QW-1:0] dvd_mag;
  logic [DW-1:0] dvs_mag;
  logic          dvd_neg, dvs_neg;
  logic          dvd_neg_r, dvs_neg_r;
  logic          running;
  logic          accept;
  logic          core_load;
  logic          core_busy, core_fin;
  logic [QW-1:0] q_mag;
  logic [DW-1:0] r_mag;
  logic [DW-1:0] q_word, r_word;
  logic          fix_ok;
  ccode_t        fix_cc;
  ccode_t        cc_r;

  ldiv_classify #(.DW(DW), .RIW(RIW)) u_cls (
    .reg_idx (reg_idx),
    .dvd     ({dvd_hi, dvd_lo}),
    .dvs     (divisor),
    .cls     (cls),
    .dvd_mag (dvd_mag),
    .dvs_mag (dvs_mag),
    .dvd_neg (dvd_neg),
    .dvs_neg (dvs_neg)
  );

  assign accept    = start && !running;
  assign core_load = accept && (cls == CLS_DIVIDE);

  ldiv_mag_core #(.DW(DW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .load    (core_load),
    .dvd_mag (dvd_mag),
    .dvs_mag (dvs_mag),
    .busy    (core_busy),
    .fin     (core_fin),
    .q_mag   (q_mag),
    .r_mag   (r_mag)
  );

  ldiv_fixup #(.DW(DW)) u_fix (
    .q_mag   (q_mag),
    .r_mag   (r_mag),
    .dvd_neg (dvd_neg_r),
    .dvs_neg (dvs_neg_r),
    .q_word  (q_word),
    .r_word  (r_word),
    .ok      (fix_ok),
    .cc      (fix_cc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      dvd_neg_r <= 1'b0;
      dvs_neg_r <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      wr_even   <= 1'b0;
      wr_odd    <= 1'b0;
      trap      <= 1'b0;
      cc_r      <= '0;
      done      <= 1'b0;
    end else begin
      done    <= 1'b0;
      trap    <= 1'b0;
      wr_even <= 1'b0;
      wr_odd  <= 1'b0;
      if (accept) begin
        unique case (cls)
          CLS_TRAP: begin
            done <= 1'b1;
            trap <= 1'b1;
          end
          CLS_ZERO: begin
            done <= 1'b1;
            cc_r <= '{n: 1'b0, z: 1'b1, v: 1'b1, c: 1'b1};
          end
          CLS_MAXNEG: begin
            done <= 1'b1;
            cc_r <= '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b0};
          end
          default: begin
            running   <= 1'b1;
            dvd_neg_r <= dvd_neg;
            dvs_neg_r <= dvs_neg;
          end
        endcase
      end
      if (core_fin) begin
        running <= 1'b0;
        done    <= 1'b1;
        cc_r    <= fix_cc;
        if (fix_ok) begin
          quotient  <= q_word;
          remainder <= r_word;
          wr_even   <= 1'b1;
          wr_odd    <= 1'b1;
        end
      end
    end
  end

  assign flag_n = cc_r.n;
  assign flag_z = cc_r.z;
  assign flag_v = cc_r.v;
  assign flag_c = cc_r.c;

  // R1: a trap never writes registers
  assert_trap_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    trap |-> (done && !wr_even && !wr_odd));

  // R3: carry only accompanies the divide-by-zero code
  assert_zero_code_R3: assert property (@(posedge clk) disable iff (rst)
    (done && flag_c) |-> (flag_v && flag_z && !flag_n && !wr_even));

  // R6: overflow suppresses writes
  assert_no_overflow_write_R6: assert property (@(posedge clk) disable iff (rst)
    (done && flag_v) |-> (!wr_even && !wr_odd));

  // R6: results hold on any completion without a write
  assert_hold_on_fail_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !wr_even) |-> ($stable(quotient) && $stable(remainder)));

  // R7: both write enables pulse together with clean flags
  assert_write_pair_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_even || wr_odd) |-> (wr_even && wr_odd && done && !flag_v && !flag_c));

  // R10: the core is never reloaded while it runs
  assert_no_reload_R10: assert property (@(posedge clk) disable iff (rst)
    core_busy |-> running);
endmodule

// File: tb/tb_long_div_unit.sv
module tb_long_div_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic [15:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
  logic [15:0] quotient, remainder;
  logic        wr_even, wr_odd, trap, flag_n, flag_z, flag_v, flag_c, done;

  long_div_unit #(.DW(16), .RIW(3)) dut (
    .clk(clk), .rst(rst), .start(start), .reg_idx(reg_idx),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
    .quotient(quotient), .remainder(remainder),
    .wr_even(wr_even), .wr_odd(wr_odd), .trap(trap),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .done(done)
  );

  always #5 clk = ~clk;

  typedef struct {
    bit          trap;
    bit          wr;
    bit          n, z, v, c;
    logic [15:0] q, r;
    int          lat;
    int          start_cyc;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic [15:0] last_q = '0, last_r = '0;
  bit          ln = 0, lz = 0, lv = 0, lc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items as completions appear
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        chk("R8", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "trap", trap, e.trap);
        chk(e.tag, "wr_even", wr_even, e.wr);
        chk(e.tag, "wr_odd", wr_odd, e.wr);
        chk(e.tag, "flags nzvc", {flag_n, flag_z, flag_v, flag_c}, {e.n, e.z, e.v, e.c});
        chk(e.tag, "quotient", quotient, e.q);
        chk(e.tag, "remainder", remainder, e.r);
        chk({e.tag, " R8"}, "latency", cyc - e.start_cyc, e.lat);
      end
    end
  end

  // driver: computes the expected outcome, queues it, launches the operation
  task automatic issue(input logic [2:0] idx, input logic [15:0] hi, input logic [15:0] lo,
                       input logic [15:0] dv, input string tag, input bit poke = 0);
    exp_t   e;
    longint a, b, qq, rr;
    a = longint'($signed({hi, lo}));
    b = longint'($signed(dv));
    e.trap = 0; e.wr = 0; e.q = last_q; e.r = last_r;
    e.n = ln; e.z = lz; e.v = lv; e.c = lc;
    e.lat = 0; e.tag = tag;
    if (idx[0]) begin
      e.trap = 1;
    end else if (b == 0) begin
      {e.n, e.z, e.v, e.c} = 4'b0111;
    end else if (a == -64'sd2147483648 && b == -1) begin
      {e.n, e.z, e.v, e.c} = 4'b0010;
    end else begin
      e.lat = 33;
      qq = a / b;
      rr = a % b;
      if (qq > 32767 || qq < -32768) begin
        e.n = (qq < 0); e.z = 0; e.v = 1; e.c = 0;
      end else begin
        e.wr = 1;
        e.q = qq[15:0];
        e.r = rr[15:0];
        e.n = (qq < 0); e.z = (qq == 0); e.v = 0; e.c = 0;
      end
    end
    last_q = e.q; last_r = e.r;
    ln = e.n; lz = e.z; lv = e.v; lc = e.c;
    e.start_cyc = cyc + 1;
    sb.push_back(e);
    start = 1; reg_idx = idx; dvd_hi = hi; dvd_lo = lo; divisor = dv;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1; reg_idx = 3'd5; divisor = 16'h0000; dvd_hi = 16'h1234;
      @(negedge clk);
      start = 0;
    end
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9: reset state
    chk("R9", "quotient", quotient, 0);
    chk("R9", "remainder", remainder, 0);
    chk("R9", "strobes", {done, trap, wr_even, wr_odd}, 0);
    chk("R9", "flags", {flag_n, flag_z, flag_v, flag_c}, 0);

    // R7 R2 R5: basic signs
    issue(3'd0, 16'h0000, 16'h0007, 16'h0002, "R7 pos/pos");
    issue(3'd2, 16'hFFFF, 16'hFFF9, 16'h0002, "R5 neg/pos");
    issue(3'd4, 16'h0000, 16'h0007, 16'hFFFE, "R5 pos/neg");
    issue(3'd6, 16'hFFFF, 16'hFFF9, 16'hFFFE, "R5 neg/neg");
    issue(3'd0, 16'hFFFF, 16'hFFFF, 16'h0005, "R5 small neg zero quotient");
    issue(3'd0, 16'h0000, 16'h0000, 16'h0005, "R7 zero dividend");
    issue(3'd2, 16'h0001, 16'h0000, 16'h0003, "R2 high word used");
    // R1: trap
    issue(3'd3, 16'h0000, 16'h0064, 16'h0007, "R1 odd index");
    // R3, R4
    issue(3'd0, 16'h1234, 16'h5678, 16'h0000, "R3 zero divisor");
    issue(3'd0, 16'h8000, 16'h0000, 16'hFFFF, "R4 most negative by minus one");
    // R6 boundaries
    issue(3'd0, 16'hFFFF, 16'h0000, 16'h0002, "R7 quotient -32768");
    issue(3'd0, 16'h0000, 16'hFFFE, 16'h0002, "R7 quotient 32767");
    issue(3'd0, 16'h0001, 16'h0000, 16'h0002, "R6 quotient 32768");
    issue(3'd0, 16'hFFFE, 16'hFFFE, 16'h0002, "R6 quotient -32769");
    issue(3'd0, 16'h8000, 16'h0000, 16'h0001, "R6 most negative by one");
    issue(3'd0, 16'h7FFF, 16'hFFFF, 16'h8000, "R6 max by min divisor");
    // R10: start during a run is ignored
    issue(3'd4, 16'h0000, 16'h3039, 16'hFF9C, "R10 busy start ignored", 1);

    for (int i = 0; i < 150; i++) begin
      logic [15:0] hi, lo, dv;
      logic [2:0]  idx;
      lo  = 16'($urandom);
      idx = {2'($urandom_range(0, 3)), 1'b0};
      case (i % 3)
        0: begin hi = 16'($urandom); dv = 16'($urandom); end
        1: begin
          hi = {16{lo[15]}};
          dv = 16'($urandom_range(1, 300));
          if ($urandom_range(0, 1) == 1) dv = -dv;
        end
        default: begin
          hi = 16'($urandom_range(0, 3));
          if ($urandom_range(0, 1) == 1) hi = ~hi;
          dv = 16'($urandom);
        end
      endcase
      issue(idx, hi, lo, dv, "R5 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule